// File: doc/BRIEF.md
# Stack Instruction Execution Unit

This unit runs the four stack operations of a 16-bit processor whose general registers live in memory: subroutine call, subroutine return, push and pop. Register R15 is the stack pointer. A push or call stores at the address held in R15 and then lowers R15 by two. A pop or return first raises R15 by two and then reads from the new address. The host core passes in the fetched instruction word, the word that follows it (used as the operand address in symbolic mode), the address of the instruction, and the workspace pointer. The unit then runs its own accesses on one synchronous 16-bit memory port. Through that port it reaches both the workspace registers (register n sits at workspace pointer + 2n) and the stack.

A pulse on `start_i` while the unit is idle starts an instruction. The unit reads R15, moves the data, writes R15 back and then raises `done_o` for one cycle with the program counter to continue from. An encoding outside the supported set raises `illegal_o` together with `done_o`. In that case the unit does not touch memory and returns the instruction's own address.

Top module: `stk_exec`

## Requirements
- R1: An instruction is in the stack group only when bits [15:11] are 00001 and bit 10 is 1 (bit 0 = LSB). Bits [9:6] then select the operation: 0010 call, 0000 return, 0100 push, 1100 pop. Every other code is illegal, and so is every word outside the group.
- R2: For call, push and pop, bits [5:4] give the addressing mode and bits [3:0] the register number n. Mode 0 uses the register at address wp_i + 2n. Mode 2 with n = 0 is symbolic and uses operand_i as the address. All other combinations are illegal. A return is legal only when bits [5:0] are all zero.
- R3: For an illegal instruction, done_o and illegal_o are high together for one cycle, no memory write is issued and pc_next_o equals pc_i.
- R4: A call stores the return address (pc_i + 2, or pc_i + 4 in symbolic mode) at mem[sp], writes sp − 2 to R15 and gives the operand address as pc_next_o.
- R5: A push stores the word read from the operand address at mem[sp], writes sp − 2 to R15 and gives the return address as pc_next_o.
- R6: A pop writes sp + 2 to R15 and then writes mem[sp + 2] to the operand address, so a pop into R15 leaves the popped word in R15. pc_next_o is the return address.
- R7: A return writes sp + 2 to R15 and gives mem[sp + 2] as pc_next_o.
- R8: start_i is accepted only while busy_o is low, and a start raised while the unit is busy has no effect. busy_o stays high up to and including the single done_o cycle.
- R9: The memory port is idle whenever busy_o is low, and mem_we_o is never high without mem_req_o.
- R10: After reset, busy_o, done_o, illegal_o and mem_req_o are low.
- R11: A push of R15 stores the stack pointer value from before the push.
- R12: Counting the accepting clock edge as the first, done_o is high after 5 edges for a call, 6 for a return, 7 for a push or pop and 1 for an illegal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the instruction on instr_i |
| instr_i | input | 16 | Instruction word |
| operand_i | input | 16 | Word following the instruction (symbolic address) |
| pc_i | input | 16 | Address of the instruction |
| wp_i | input | 16 | Workspace pointer |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Unsupported encoding, valid with done_o |
| pc_next_o | output | 16 | Program counter to continue from, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable of the request |
| mem_addr_o | output | 16 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |

## Verification
The checker watches the port rules on every cycle. It confirms that the memory stays quiet while idle, that a write always comes with a request, and that busy only rises after a start. It also confirms that done is a single pulse, that an illegal instruction completes without any write, and that a legal one completes after one or two writes. Only the bench can show the data itself. It sweeps every register and the symbolic mode for each operation, plus the illegal encodings, against a reference memory. That covers the value moved, the R15 written back, the pop into R15, the push of R15, the returned program counter, the latency, and the fact that a start raised mid-instruction is ignored.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int IW = 16;

  typedef enum logic [2:0] {OP_CALL, OP_RET, OP_PUSH, OP_POP, OP_NONE} stk_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SP_RD, S_SP_CAP, S_OP_RD, S_OP_CAP,
    S_STK_RD, S_STK_CAP, S_STK_WR, S_SP_WR, S_DST_WR, S_DONE
  } stk_state_e;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output stk_op_e       op_o,
  output logic          sym_o,
  output logic [3:0]    rn_o,
  output logic          legal_o
);
  logic       grp;
  logic [1:0] mode;
  logic       mode_ok;

  always_comb begin
    grp     = (instr_i[15:11] == 5'b00001) && instr_i[10];
    mode    = instr_i[5:4];
    rn_o    = instr_i[3:0];
    sym_o   = (mode == 2'b10);
    mode_ok = (mode == 2'b00) || ((mode == 2'b10) && (instr_i[3:0] == 4'd0));
    op_o    = OP_NONE;
    if (grp) begin
      unique case (instr_i[9:6])
        4'b0010: op_o = OP_CALL;
        4'b0000: op_o = OP_RET;
        4'b0100: op_o = OP_PUSH;
        4'b1100: op_o = OP_POP;
        default: op_o = OP_NONE;
      endcase
    end
    unique case (op_o)
      OP_NONE: legal_o = 1'b0;
      OP_RET:  legal_o = (instr_i[5:0] == 6'd0);
      default: legal_o = mode_ok;
    endcase
  end
endmodule

// File: rtl/stk_agen.sv
module stk_agen #(
  parameter int DW     = 16,
  parameter int SP_IDX = 15
) (
  input  logic [DW-1:0] wp_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] operand_i,
  input  logic          sym_i,
  input  logic [3:0]    rn_i,
  output logic [DW-1:0] ea_o,
  output logic [DW-1:0] ret_pc_o,
  output logic [DW-1:0] sp_addr_o
);
  localparam logic [DW-1:0] SP_OFS = DW'(2 * SP_IDX);
  localparam logic [DW-1:0] STEP1  = DW'(2);
  localparam logic [DW-1:0] STEP2  = DW'(4);

  logic [DW-1:0] reg_ofs;

  assign reg_ofs   = {{(DW-5){1'b0}}, rn_i, 1'b0};
  assign ea_o      = sym_i ? operand_i : (wp_i + reg_ofs);
  assign ret_pc_o  = pc_i + (sym_i ? STEP2 : STEP1);
  assign sp_addr_o = wp_i + SP_OFS;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  stk_op_e       op_i,
  input  logic          legal_i,
  input  logic [DW-1:0] ea_i,
  input  logic [DW-1:0] ret_pc_i,
  input  logic [DW-1:0] sp_addr_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic [DW-1:0] pc_next_o
);
  localparam logic [DW-1:0] WSTEP = DW'(2);

  stk_state_e    state_q;
  stk_op_e       op_q;
  logic          ill_q;
  logic [DW-1:0] ea_q, ret_q, spa_q, sp_q, val_q, pc_q;
  logic          grows;

  assign grows = (op_q == OP_CALL) || (op_q == OP_PUSH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_NONE;
      ill_q   <= 1'b0;
      ea_q    <= '0;
      ret_q   <= '0;
      spa_q   <= '0;
      sp_q    <= '0;
      val_q   <= '0;
      pc_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q  <= op_i;
          ea_q  <= ea_i;
          ret_q <= ret_pc_i;
          spa_q <= sp_addr_i;
          ill_q <= !legal_i;
          if (!legal_i) begin
            pc_q    <= pc_i;
            state_q <= S_DONE;
          end else begin
            state_q <= S_SP_RD;
          end
        end
        S_SP_RD:  state_q <= S_SP_CAP;
        S_SP_CAP: begin
          sp_q <= mem_rdata_i;
          unique case (op_q)
            OP_CALL: state_q <= S_STK_WR;
            OP_PUSH: state_q <= S_OP_RD;
            default: state_q <= S_STK_RD;
          endcase
        end
        S_OP_RD:  state_q <= S_OP_CAP;
        S_OP_CAP: begin
          val_q   <= mem_rdata_i;
          state_q <= S_STK_WR;
        end
        S_STK_RD:  state_q <= S_STK_CAP;
        S_STK_CAP: begin
          val_q   <= mem_rdata_i;
          state_q <= S_SP_WR;
        end
        S_STK_WR: state_q <= S_SP_WR;
        S_SP_WR: begin
          unique case (op_q)
            OP_CALL: pc_q <= ea_q;
            OP_RET:  pc_q <= val_q;
            default: pc_q <= ret_q;
          endcase
          state_q <= (op_q == OP_POP) ? S_DST_WR : S_DONE;
        end
        S_DST_WR: state_q <= S_DONE;
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_SP_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = spa_q;
      end
      S_OP_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ea_q;
      end
      S_STK_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_q + WSTEP;
      end
      S_STK_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q;
        mem_wdata_o = (op_q == OP_CALL) ? ret_q : val_q;
      end
      S_SP_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = spa_q;
        mem_wdata_o = grows ? (sp_q - WSTEP) : (sp_q + WSTEP);
      end
      S_DST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ea_q;
        mem_wdata_o = val_q;
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign illegal_o = done_o && ill_q;
  assign pc_next_o = pc_q;
endmodule

// File: rtl/stk_exec.sv
module stk_exec
  import stk_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SP_IDX = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [15:0]   instr_i,
  input  logic [DW-1:0] operand_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] wp_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic [DW-1:0] pc_next_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  stk_op_e       dec_op;
  logic          dec_sym, dec_legal;
  logic [3:0]    dec_rn;
  logic [DW-1:0] ea, ret_pc, sp_addr;

  stk_decode u_dec (
    .instr_i (instr_i),
    .op_o    (dec_op),
    .sym_o   (dec_sym),
    .rn_o    (dec_rn),
    .legal_o (dec_legal)
  );

  stk_agen #(.DW(DW), .SP_IDX(SP_IDX)) u_agen (
    .wp_i      (wp_i),
    .pc_i      (pc_i),
    .operand_i (operand_i),
    .sym_i     (dec_sym),
    .rn_i      (dec_rn),
    .ea_o      (ea),
    .ret_pc_o  (ret_pc),
    .sp_addr_o (sp_addr)
  );

  stk_seq #(.DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (dec_op),
    .legal_i     (dec_legal),
    .ea_i        (ea),
    .ret_pc_i    (ret_pc),
    .sp_addr_i   (sp_addr),
    .pc_i        (pc_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .pc_next_o   (pc_next_o)
  );
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic illegal_o,
  input logic mem_req_o,
  input logic mem_we_o
);
  logic [2:0] wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wr_cnt <= '0;
    else if (start_i && !busy_o) wr_cnt <= '0;
    else if (mem_we_o && wr_cnt != 3'd7) wr_cnt <= wr_cnt + 3'd1;
  end

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  p_we_has_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  p_busy_from_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_illegal_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (wr_cnt == 3'd0 && !mem_req_o));
  p_write_budget_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o) |-> (wr_cnt == 3'd1 || wr_cnt == 3'd2));
endmodule

bind stk_exec stk_exec_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/stk_exec_test.sv
module stk_exec_test;
  localparam logic [15:0] WP = 16'h0040;
  localparam int R15W = 32 + 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, opnd = '0, pc = '0, wp = WP;
  logic        busy, done, illegal, mreq, mwe;
  logic [15:0] pc_next, maddr, mwdata, mrdata;

  logic [15:0] mem  [256];
  logic [15:0] refm [256];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  stk_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .operand_i(opnd), .pc_i(pc), .wp_i(wp), .busy_o(busy), .done_o(done),
    .illegal_o(illegal), .pc_next_o(pc_next), .mem_req_o(mreq),
    .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata)
  );

  always @(posedge clk) begin
    if (mreq) begin
      if (mwe) mem[maddr[8:1]] <= mwdata;
      else     mrdata <= mem[maddr[8:1]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 call, 1 ret, 2 push, 3 pop, 4 illegal
  function automatic int classify(input logic [15:0] w, output bit sym, output logic [3:0] rn);
    int k;
    sym = (w[5:4] == 2'b10);
    rn  = w[3:0];
    if (w[15:10] != 6'b000011) return 4;
    case (w[9:6])
      4'b0010: k = 0;
      4'b0000: k = 1;
      4'b0100: k = 2;
      4'b1100: k = 3;
      default: return 4;
    endcase
    if (k == 1) return (w[5:0] == 6'd0) ? 1 : 4;
    if (w[5:4] == 2'b00 || (w[5:4] == 2'b10 && w[3:0] == 4'd0)) return k;
    return 4;
  endfunction

  task automatic run(input logic [15:0] w, input logic [15:0] op_word,
                     input logic [15:0] at, input logic [15:0] sp,
                     input bit hold, input string req);
    bit sym; logic [3:0] rn; int kind, lat, exp_lat, bad;
    logic [15:0] ea, rpc, exp_pc, v;
    mem[R15W] = sp; refm[R15W] = sp;
    kind = classify(w, sym, rn);
    ea   = sym ? op_word : WP + {11'd0, rn, 1'b0};
    rpc  = at + (sym ? 16'd4 : 16'd2);
    case (kind)
      0: begin refm[sp[8:1]] = rpc; refm[R15W] = sp - 16'd2; exp_pc = ea; exp_lat = 5; end
      1: begin refm[R15W] = sp + 16'd2; exp_pc = refm[(sp + 16'd2) >> 1]; exp_lat = 6; end
      2: begin v = refm[ea[8:1]]; refm[sp[8:1]] = v; refm[R15W] = sp - 16'd2; exp_pc = rpc; exp_lat = 7; end
      3: begin refm[R15W] = sp + 16'd2; v = refm[(sp + 16'd2) >> 1]; refm[ea[8:1]] = v; exp_pc = rpc; exp_lat = 7; end
      default: begin exp_pc = at; exp_lat = 1; end
    endcase
    @(negedge clk);
    start = 1'b1; instr = w; opnd = op_word; pc = at;
    @(negedge clk);
    lat = 1;
    start = hold;
    if (hold) begin instr = 16'h0D05; pc = 16'h0002; end
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      start = hold && (lat < 3);
    end
    start = 1'b0;
    chk(done, {req, " done"}, 32'(done), 32'd1);
    chk(lat == exp_lat, {"R12 latency ", req}, 32'(lat), 32'(exp_lat));
    chk(illegal == (kind == 4), {req, " illegal flag"}, 32'(illegal), 32'(kind == 4));
    chk(pc_next == exp_pc, {req, " pc_next"}, 32'(pc_next), 32'(exp_pc));
    @(negedge clk);
    chk(!done && !busy, "R8 done single cycle", 32'({done, busy}), 32'd0);
    bad = -1;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i] && bad < 0) bad = i;
    chk(bad < 0, {req, " memory"}, (bad < 0) ? 32'd0 : 32'(mem[bad]),
        (bad < 0) ? 32'd0 : 32'(refm[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 16'h1357) ^ 16'h5A3C;
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk({busy, done, illegal, mreq} == 4'b0, "R10 reset state", 32'({busy, done, illegal, mreq}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, mreq} == 2'b0, "R10 idle after reset", 32'({busy, mreq}), 32'd0);

    // legal sweep: register modes and symbolic
    for (int n = 0; n < 17; n++) begin
      logic [15:0] lo;
      lo = (n == 16) ? 16'h0020 : 16'(n);
      run(16'h0C80 | lo, 16'h01A0 + 16'(2 * n), 16'h0300 + 16'(4 * n), 16'h0100 + 16'(2 * n), 1'b0, "R4 call");
      run(16'h0D00 | lo, 16'h01A2 + 16'(2 * n), 16'h0400 + 16'(4 * n), 16'h0120 + 16'(2 * n), 1'b0, "R5 push");
      run(16'h0F00 | lo, 16'h01C0 + 16'(2 * n), 16'h0500 + 16'(4 * n), 16'h0110 + 16'(2 * n), 1'b0, "R6 pop");
    end
    run(16'h0D0F, 16'h0000, 16'h0600, 16'h0130, 1'b0, "R11 push r15");
    run(16'h0F0F, 16'h0000, 16'h0602, 16'h0134, 1'b0, "R6 pop into r15");
    for (int k = 0; k < 8; k++)
      run(16'h0C00, 16'h0000, 16'h0700, 16'h0100 + 16'(6 * k), 1'b0, "R7 ret");

    // illegal sweep
    for (int b = 0; b < 3; b++) begin
      logic [15:0] base;
      base = (b == 0) ? 16'h0C80 : (b == 1) ? 16'h0D00 : 16'h0F00;
      for (int m = 1; m < 4; m++)
        for (int n = 0; n < 16; n++)
          if (!(m == 2 && n == 0))
            run(base | 16'(m << 4) | 16'(n), 16'h01A0, 16'h0800, 16'h0100, 1'b0, "R2 bad mode R3");
    end
    for (int bt = 0; bt < 6; bt++)
      run(16'h0C00 | 16'(1 << bt), 16'h0000, 16'h0810, 16'h0100, 1'b0, "R2 ret low bits R3");
    run(16'h0E00, 16'h0000, 16'h0820, 16'h0100, 1'b0, "R1 unused code R3");
    run(16'h0C40, 16'h0000, 16'h0822, 16'h0100, 1'b0, "R1 unused code R3");
    run(16'h0880, 16'h0000, 16'h0824, 16'h0100, 1'b0, "R1 shift group R3");
    run(16'h1C80, 16'h0000, 16'h0826, 16'h0100, 1'b0, "R1 other group R3");

    // start while busy is ignored
    run(16'h0C83, 16'h0000, 16'h0900, 16'h0140, 1'b1, "R8 start while busy");
    run(16'h0D04, 16'h0000, 16'h0904, 16'h0144, 1'b1, "R8 start while busy");
    @(negedge clk);
    chk({busy, mreq} == 2'b0, "R9 idle port", 32'({busy, mreq}), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule